// File: doc/BRIEF.md
# Serial Sampling Converter Frame Controller

This block is the digital sequencer for a 12-bit sampling converter with two analog inputs. A host drives an active-low select line and a serial clock. The block runs in a faster system clock, synchronises both host lines and detects their edges there. It counts serial clock edges within each select-active frame. From that count it opens the sampling window, tells an external successive-approximation engine when to start, and shifts the previous result out MSB first on a serial data line. That data line has a separate output-enable, which stands for the tri-state driver.

The length of each frame also steers the two-way input multiplexer. A frame of four to seven serial clocks sends it back to input 0. A frame that runs its full sixteen clocks and lets the conversion finish moves it to the other input when the select rises. A select that rises while a conversion is still running aborts that conversion. A low-power flag is raised when a conversion completes and is cleared by the next select fall.

Top module: `adc_frame_ctrl`

## Requirements
- R1: While the select is high the data output-enable is low. A falling select raises the output-enable and drives the MSB of the held result on the data line before the first serial clock. After reset the output-enable is low, the mux selects input 0, the low-power flag is high and the held result is zero.
- R2: A frame carries 16 bit slots. Slots 1 to 12 hold the held result MSB first, and slots 13 to 16 are driven as 0.
- R3: The data line changes only on rising serial clock edges. Slot k is shown from rising edge k (from the select fall for k = 1) until rising edge k+1, so it is stable across falling edge k.
- R4: The output-enable drops on the 17th rising serial clock edge of a frame.
- R5: The sampling-window output is high from the 5th rising serial clock edge until the 16th falling edge, and low at all other times.
- R6: The conversion-start output pulses for one system clock after the 16th falling serial edge. A done strobe during the conversion captures the 12-bit result input, and that value is shifted out in the next frame.
- R7: If the select rises while a conversion is running and no done strobe arrives in that cycle, the abort output pulses once and the held result becomes zero.
- R8: A frame that ends after 4 to 7 rising serial clock edges sets the mux select to input 0.
- R9: A frame in which the conversion completed toggles the mux select when the select rises. The mux select does not change while a conversion runs.
- R10: The mux select is left unchanged by a frame of fewer than 4 edges, by a frame of 8 to 15 edges, and by a frame of 16 or more edges whose conversion did not complete.
- R11: The low-power flag rises when a conversion completes and falls on the next select fall.
- R12: A done strobe that arrives while no conversion is running is ignored: the held result does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_in | input | 1 | Host serial clock, asynchronous, idles low |
| sel_n_in | input | 1 | Host active-low select / frame start, asynchronous |
| conv_done_i | input | 1 | Done strobe from the external conversion engine |
| result_i | input | 12 | Conversion result, valid with the done strobe |
| conv_start_o | output | 1 | One-cycle request to start a conversion |
| conv_abort_o | output | 1 | One-cycle pulse when a running conversion is cut short |
| sample_o | output | 1 | Sampling window open |
| sdo_o | output | 1 | Serial data bit |
| sdo_oe_o | output | 1 | Serial data output-enable (low means high impedance) |
| mux_sel_o | output | 1 | Analog input select, 0 or 1 |
| pwr_down_o | output | 1 | Low-power flag |

## Verification
The assertions assume that the serial clock and the select change no faster than every few system clocks. Under that assumption each host edge becomes exactly one synchronised pulse, and a select edge never lands in the same system cycle as a serial clock edge. They also assume that the conversion engine raises its done strobe only for a single cycle. The stimulus holds every serial clock phase and every select level for several system clocks and issues one-cycle done strobes. It also spaces select edges well apart from serial clock edges, so all of this holds throughout.

// File: rtl/adc_frame_pkg.sv
package adc_frame_pkg;

  localparam int RES_W_DEF     = 12;
  localparam int FRAME_LEN_DEF = 16;
  localparam int SAMPLE_AT_DEF = 5;
  localparam int RST_MIN_DEF   = 4;
  localparam int RST_MAX_DEF   = 7;

  typedef enum logic [1:0] {
    MUX_HOLD  = 2'd0,
    MUX_RESET = 2'd1,
    MUX_STEP  = 2'd2
  } mux_act_e;

  // Decide the mux action from the edge count of a finished frame.
  function automatic mux_act_e mux_decide(input int edges, input logic done,
                                          input int rmin, input int rmax,
                                          input int flen);
    if (edges >= rmin && edges <= rmax) return MUX_RESET;
    if (done && edges >= flen)          return MUX_STEP;
    return MUX_HOLD;
  endfunction

endpackage

// File: rtl/adc_edge_sync.sv
module adc_edge_sync #(
  parameter int   STAGES = 2,
  parameter logic INIT   = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise_o,
  output logic fall_o
);

  logic [STAGES:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= {(STAGES+1){INIT}};
    else     pipe <= {pipe[STAGES-1:0], din};
  end

  assign rise_o = pipe[STAGES-1] & ~pipe[STAGES];
  assign fall_o = ~pipe[STAGES-1] & pipe[STAGES];

endmodule

// File: rtl/adc_frame_seq.sv
module adc_frame_seq #(
  parameter int FRAME_LEN = 16,
  parameter int SAMPLE_AT = 5,
  parameter int CNT_W     = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_fall_i,
  input  logic             sel_rise_i,
  input  logic             sclk_rise_i,
  input  logic             sclk_fall_i,
  input  logic             conv_done_i,
  output logic             active_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             sample_o,
  output logic             conv_start_o,
  output logic             converting_o,
  output logic             conv_abort_o,
  output logic             capture_o,
  output logic             abort_now_o,
  output logic             frame_end_o,
  output logic             frame_done_o,
  output logic             shift_o,
  output logic             oe_off_o,
  output logic             pwr_down_o
);

  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] LAST_CLK = CNT_W'(FRAME_LEN);
  localparam logic [CNT_W-1:0] OPEN_CNT = CNT_W'(SAMPLE_AT - 1);

  logic done_seen;
  logic clk_ok;

  assign clk_ok       = active_o & ~sel_rise_i & ~sel_fall_i;
  assign capture_o    = conv_done_i & converting_o;
  assign abort_now_o  = sel_rise_i & active_o & converting_o & ~conv_done_i;
  assign frame_end_o  = sel_rise_i & active_o;
  assign frame_done_o = done_seen | capture_o;
  assign shift_o      = clk_ok & sclk_rise_i & (cnt_o != '0) & (cnt_o < LAST_CLK);
  assign oe_off_o     = clk_ok & sclk_rise_i & (cnt_o == LAST_CLK);

  always_ff @(posedge clk) begin
    if (rst) begin
      active_o     <= 1'b0;
      cnt_o        <= '0;
      sample_o     <= 1'b0;
      conv_start_o <= 1'b0;
      converting_o <= 1'b0;
      conv_abort_o <= 1'b0;
      done_seen    <= 1'b0;
      pwr_down_o   <= 1'b1;
    end else begin
      conv_start_o <= 1'b0;
      conv_abort_o <= 1'b0;
      if (sel_fall_i) begin
        active_o   <= 1'b1;
        cnt_o      <= '0;
        sample_o   <= 1'b0;
        done_seen  <= 1'b0;
        pwr_down_o <= 1'b0;
      end else if (frame_end_o) begin
        active_o <= 1'b0;
        sample_o <= 1'b0;
        if (abort_now_o) begin
          converting_o <= 1'b0;
          conv_abort_o <= 1'b1;
        end
      end else if (active_o) begin
        if (sclk_rise_i && cnt_o != CNT_MAX) cnt_o <= cnt_o + 1'b1;
        if (sclk_rise_i && cnt_o == OPEN_CNT) sample_o <= 1'b1;
        if (sclk_fall_i && cnt_o == LAST_CLK) begin
          sample_o     <= 1'b0;
          conv_start_o <= 1'b1;
          converting_o <= 1'b1;
        end
      end
      if (capture_o) begin
        converting_o <= 1'b0;
        done_seen    <= 1'b1;
        pwr_down_o   <= 1'b1;
      end
    end
  end

  AST_START_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
    conv_start_o |=> !conv_start_o);  // R6
  AST_SAMPLE_NOT_CONV: assert property (@(posedge clk) disable iff (rst)
    !(sample_o && converting_o));  // R5
  AST_LOWPWR_IDLE: assert property (@(posedge clk) disable iff (rst)
    pwr_down_o |-> !converting_o);  // R11

endmodule

// File: rtl/adc_result_shifter.sv
module adc_result_shifter #(
  parameter int RES_W     = 12,
  parameter int FRAME_LEN = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             shift_i,
  input  logic             oe_off_i,
  input  logic             drop_i,
  input  logic             capture_i,
  input  logic             clear_i,
  input  logic [RES_W-1:0] result_i,
  output logic             sdo_o,
  output logic             sdo_oe_o
);

  localparam int PAD_W = FRAME_LEN - RES_W;

  logic [RES_W-1:0]     held;
  logic [FRAME_LEN-1:0] sreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      held     <= '0;
      sreg     <= '0;
      sdo_oe_o <= 1'b0;
    end else begin
      if (capture_i)    held <= result_i;
      else if (clear_i) held <= '0;
      if (load_i) begin
        sreg     <= {held, {PAD_W{1'b0}}};
        sdo_oe_o <= 1'b1;
      end else begin
        if (shift_i) sreg <= {sreg[FRAME_LEN-2:0], 1'b0};
        if (oe_off_i || drop_i) sdo_oe_o <= 1'b0;
      end
    end
  end

  assign sdo_o = sreg[FRAME_LEN-1];

endmodule

// File: rtl/adc_chan_select.sv
module adc_chan_select #(
  parameter int FRAME_LEN = 16,
  parameter int RST_MIN   = 4,
  parameter int RST_MAX   = 7,
  parameter int CNT_W     = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_end_i,
  input  logic             frame_done_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             mux_sel_o
);
  import adc_frame_pkg::*;

  mux_act_e act;

  always_comb act = mux_decide(int'(cnt_i), frame_done_i, RST_MIN, RST_MAX, FRAME_LEN);

  always_ff @(posedge clk) begin
    if (rst) begin
      mux_sel_o <= 1'b0;
    end else if (frame_end_i) begin
      case (act)
        MUX_RESET: mux_sel_o <= 1'b0;
        MUX_STEP:  mux_sel_o <= ~mux_sel_o;
        default:   mux_sel_o <= mux_sel_o;
      endcase
    end
  end

  AST_SHORT_FRAME_RESET: assert property (@(posedge clk) disable iff (rst)
    (frame_end_i && cnt_i >= CNT_W'(RST_MIN) && cnt_i <= CNT_W'(RST_MAX)) |=> !mux_sel_o);  // R8
  AST_IDLE_MUX_STABLE: assert property (@(posedge clk) disable iff (rst)
    !frame_end_i |=> $stable(mux_sel_o));  // R10

endmodule

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl #(
  parameter int RES_W       = adc_frame_pkg::RES_W_DEF,
  parameter int FRAME_LEN   = adc_frame_pkg::FRAME_LEN_DEF,
  parameter int SAMPLE_AT   = adc_frame_pkg::SAMPLE_AT_DEF,
  parameter int RST_MIN     = adc_frame_pkg::RST_MIN_DEF,
  parameter int RST_MAX     = adc_frame_pkg::RST_MAX_DEF,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sclk_in,
  input  logic             sel_n_in,
  input  logic             conv_done_i,
  input  logic [RES_W-1:0] result_i,
  output logic             conv_start_o,
  output logic             conv_abort_o,
  output logic             sample_o,
  output logic             sdo_o,
  output logic             sdo_oe_o,
  output logic             mux_sel_o,
  output logic             pwr_down_o
);

  localparam int CNT_W = $clog2(FRAME_LEN + 2) + 1;

  logic sclk_rise, sclk_fall, sel_rise, sel_fall;
  logic active, converting, capture, abort_now, frame_end, frame_done, shift, oe_off;
  logic [CNT_W-1:0] cnt;

  localparam int N_SYNC = 2;
  logic [N_SYNC-1:0] sync_in, sync_rise, sync_fall;
  assign sync_in = {sel_n_in, sclk_in};

  for (genvar g = 0; g < N_SYNC; g++) begin : g_sync
    adc_edge_sync #(.STAGES(SYNC_STAGES), .INIT(g == 1)) u_sync (
      .clk(clk), .rst(rst), .din(sync_in[g]),
      .rise_o(sync_rise[g]), .fall_o(sync_fall[g]));
  end

  assign sclk_rise = sync_rise[0];
  assign sclk_fall = sync_fall[0];
  assign sel_rise  = sync_rise[1];
  assign sel_fall  = sync_fall[1];

  adc_frame_seq #(.FRAME_LEN(FRAME_LEN), .SAMPLE_AT(SAMPLE_AT), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .sel_fall_i(sel_fall), .sel_rise_i(sel_rise),
    .sclk_rise_i(sclk_rise), .sclk_fall_i(sclk_fall), .conv_done_i(conv_done_i),
    .active_o(active), .cnt_o(cnt), .sample_o(sample_o), .conv_start_o(conv_start_o),
    .converting_o(converting), .conv_abort_o(conv_abort_o), .capture_o(capture),
    .abort_now_o(abort_now), .frame_end_o(frame_end), .frame_done_o(frame_done),
    .shift_o(shift), .oe_off_o(oe_off), .pwr_down_o(pwr_down_o));

  adc_result_shifter #(.RES_W(RES_W), .FRAME_LEN(FRAME_LEN)) u_shift (
    .clk(clk), .rst(rst), .load_i(sel_fall), .shift_i(shift), .oe_off_i(oe_off),
    .drop_i(sel_rise), .capture_i(capture), .clear_i(abort_now), .result_i(result_i),
    .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o));

  adc_chan_select #(.FRAME_LEN(FRAME_LEN), .RST_MIN(RST_MIN), .RST_MAX(RST_MAX),
                    .CNT_W(CNT_W)) u_mux (
    .clk(clk), .rst(rst), .frame_end_i(frame_end), .frame_done_i(frame_done),
    .cnt_i(cnt), .mux_sel_o(mux_sel_o));

  AST_OE_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    !active |-> !sdo_oe_o);  // R1
  AST_OE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    (active && cnt > CNT_W'(FRAME_LEN)) |-> !sdo_oe_o);  // R4
  AST_MUX_HOLD_CONV: assert property (@(posedge clk) disable iff (rst)
    converting |=> $stable(mux_sel_o));  // R9

endmodule

// File: tb/adc_frame_ctrl_tb.sv
module adc_frame_ctrl_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0;
  logic sel_n = 1'b1;
  logic done = 1'b0;
  logic [11:0] res = '0;
  logic conv_start, conv_abort, sample, sdo, sdo_oe, mux_sel, pwr_down;

  int n_tests = 0;
  int n_fail  = 0;
  int starts  = 0;
  int aborts  = 0;

  always #2.5 clk = ~clk;

  adc_frame_ctrl dut_i (
    .clk(clk), .rst(rst), .sclk_in(sclk), .sel_n_in(sel_n), .conv_done_i(done),
    .result_i(res), .conv_start_o(conv_start), .conv_abort_o(conv_abort),
    .sample_o(sample), .sdo_o(sdo), .sdo_oe_o(sdo_oe), .mux_sel_o(mux_sel),
    .pwr_down_o(pwr_down));

  always @(negedge clk) begin
    if (conv_start) starts++;
    if (conv_abort) aborts++;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One select-active frame of n serial clocks; exp_out is the held result
  task automatic frame(input int n, input bit give_done, input logic [11:0] code,
                       input logic [11:0] exp_out);
    logic [15:0] word;
    int s0, a0;
    word = '0;
    s0 = starts;
    a0 = aborts;
    sel_n = 1'b0;
    wclk(8);
    chk(sdo_oe == 1'b1, "R1", "oe after select fall", sdo_oe, 1);
    chk(sdo == exp_out[11], "R1", "MSB before first clock", sdo, exp_out[11]);
    chk(pwr_down == 1'b0, "R11", "low-power cleared by select fall", pwr_down, 0);
    for (int k = 1; k <= n; k++) begin
      sclk = 1'b1;
      wclk(6);
      if (k <= 16) begin
        chk(sdo_oe == 1'b1, "R4", "oe within frame", sdo_oe, 1);
        word[16-k] = sdo;
      end
      if (k == 17) chk(sdo_oe == 1'b0, "R4", "oe after 17th rise", sdo_oe, 0);
      chk(sample == (k >= 5 && k <= 16), "R5", "window in high phase", sample,
          (k >= 5 && k <= 16));
      sclk = 1'b0;
      wclk(6);
      if (k <= 16)
        chk(sdo == word[16-k], "R3", "bit stable across falling edge", sdo, word[16-k]);
      chk(sample == (k >= 5 && k <= 15), "R5", "window in low phase", sample,
          (k >= 5 && k <= 15));
      if (k == 16) chk(starts == s0 + 1, "R6", "start pulses", starts, s0 + 1);
    end
    if (n < 16) chk(starts == s0, "R6", "no start in short frame", starts, s0);
    if (give_done && n >= 16) begin
      res  = code;
      done = 1'b1;
      wclk(1);
      done = 1'b0;
      wclk(3);
      chk(pwr_down == 1'b1, "R11", "low-power after done", pwr_down, 1);
    end
    sel_n = 1'b1;
    wclk(8);
    chk(sdo_oe == 1'b0, "R1", "oe while select high", sdo_oe, 0);
    if (n >= 16) begin
      chk(word[15:4] == exp_out, "R2", "result slots 1-12", word[15:4], exp_out);
      chk(word[3:0] == 4'h0, "R2", "slots 13-16 zero", word[3:0], 0);
      chk(aborts == a0 + (give_done ? 0 : 1), "R7", "abort count", aborts,
          a0 + (give_done ? 0 : 1));
    end else begin
      chk(aborts == a0, "R7", "no abort in short frame", aborts, a0);
    end
  endtask

  task automatic chk_mux(input logic exp, input string req, input string what);
    chk(mux_sel == exp, req, what, mux_sel, exp);
  endtask

  task automatic t_reset;
    chk(sdo_oe == 1'b0, "R1", "reset oe", sdo_oe, 0);
    chk_mux(1'b0, "R1", "reset mux");
    chk(pwr_down == 1'b1, "R1", "reset low-power", pwr_down, 1);
    chk(sample == 1'b0, "R5", "reset window", sample, 0);
  endtask

  task automatic t_full_frames;
    frame(16, 1'b1, 12'hA5C, 12'h000);
    chk_mux(1'b1, "R9", "completed frame steps mux");
    frame(17, 1'b1, 12'h3F1, 12'hA5C);
    chk_mux(1'b0, "R9", "second completed frame steps back");
    frame(16, 1'b1, 12'h800, 12'h3F1);
    chk_mux(1'b1, "R6", "result shown next frame, mux stepped");
  endtask

  task automatic t_mux_lengths;
    frame(5, 1'b0, 12'h0, 12'h800);
    chk_mux(1'b0, "R8", "5-clock frame resets mux");
    frame(16, 1'b1, 12'h001, 12'h800);
    chk_mux(1'b1, "R9", "step before length checks");
    frame(2, 1'b0, 12'h0, 12'h001);
    chk_mux(1'b1, "R10", "2-clock frame holds mux");
    frame(10, 1'b0, 12'h0, 12'h001);
    chk_mux(1'b1, "R10", "10-clock frame holds mux");
    frame(7, 1'b0, 12'h0, 12'h001);
    chk_mux(1'b0, "R8", "7-clock frame resets mux");
    frame(16, 1'b1, 12'h0C3, 12'h001);
    frame(4, 1'b0, 12'h0, 12'h0C3);
    chk_mux(1'b0, "R8", "4-clock frame resets mux");
    frame(16, 1'b1, 12'h5A5, 12'h0C3);
    chk_mux(1'b1, "R9", "step again");
    frame(3, 1'b0, 12'h0, 12'h5A5);
    chk_mux(1'b1, "R10", "3-clock frame holds mux");
    frame(8, 1'b0, 12'h0, 12'h5A5);
    chk_mux(1'b1, "R10", "8-clock frame holds mux");
  endtask

  task automatic t_abort_and_stray;
    frame(16, 1'b0, 12'h0, 12'h5A5);
    chk_mux(1'b1, "R10", "aborted frame holds mux");
    res  = 12'hFFF;
    done = 1'b1;
    wclk(1);
    done = 1'b0;
    wclk(4);
    frame(16, 1'b1, 12'h777, 12'h000);
    chk_mux(1'b0, "R12", "stray done ignored, result cleared by abort (R7)");
    frame(16, 1'b1, 12'h123, 12'h777);
    chk_mux(1'b1, "R9", "final step");
  endtask

  initial begin
    wclk(5);
    rst = 1'b0;
    wclk(5);
    t_reset();
    t_full_frames();
    t_mux_lengths();
    t_abort_and_stray();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule